// File: doc/BRIEF.md
# Programmable Horizontal Video Timing Generator

This block derives horizontal video timing from the output pixel clock. A free-running horizontal counter restarts every line. Four counts, all in output clock cycles, set the line: the line length, the H sync width, and the offsets of the start and the end of active video. Both offsets are measured from the leading edge of H sync. The outputs are an H sync level, an active-video level, one-cycle strobes at the start and end of active video, a line-start strobe, and a field-identification pulse. The field pulse comes from a small line and field counter.

A 6-bit standard code picks the counts. The code comes from input pins, or from a host register when a control bit selects the host. Each code has built-in counts. The code 62 selects custom mode, in which the host writes the four counts. Any change of code or counts waits for the end of the current line, so every line on the outputs has the full length of one timing set.

The host reaches the block through a small synchronous register bus. It has a word address, write data, a write enable and registered read data.

Top module: `hline_timing_gen`

## Requirements
- R1: After synchronous reset the control word and the host standard register read 0. The counter sits at count 0, so `line_start` is 1.
- R2: `line_start` is high for one cycle per line, and successive line starts are exactly line-length cycles apart.
- R3: `hsync` is high for the first H-sync-width cycles of each line, counting from the line start.
- R4: `active` is high from the SAV offset up to, but not including, the EAV offset. `sav_stb` and `eav_stb` each fire for one cycle at those offsets from the line start.
- R5: Code 0 gives line 32, sync 4, SAV 8 and EAV 28. Code 1 gives 48, 6, 12 and 44. Every other code except 62 uses the code 0 counts.
- R6: The four timing registers take writes only while the effective code is 62. For any other code, writes to them are dropped and they read back the built-in counts of that code.
- R7: Control bit 0 (host select, reset 0) makes the host standard register the effective code. While it is set, the pins have no effect.
- R8: The host standard register keeps only data bits 5:0. Bits 15:6 read as zero.
- R9: The line counter counts LINES_PER_FIELD lines per field, and fields alternate even and odd. `field_id` is high for the first line of each even field. When control bit 1 is set, it stays high for the whole even field instead.
- R10: A change of standard, or a write to a custom count, takes effect only at the next line start. The line in progress keeps its length.
- R11: The word addresses are 0 control, 1 host standard, 2 line length, 3 sync width, 4 SAV and 5 EAV. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 16 | Registered read data |
| std_pins | input | 6 | Standard code from pins |
| hsync | output | 1 | H sync level |
| active | output | 1 | Active-video level |
| sav_stb | output | 1 | Start-of-active-video strobe |
| eav_stb | output | 1 | End-of-active-video strobe |
| line_start | output | 1 | Line-start strobe |
| field_id | output | 1 | Field-identification pulse |

## Verification
The bench measures whole lines and computes the expected values itself. For each line it records the period, the H sync high count, the strobe positions and the active count, and runs this for code 0, code 1, an unknown code and a custom set. Those four cases tell apart table lookup, fallback and the custom registers. A mid-line switch of code tests that the line in progress keeps its old length. The pins are then moved while host select is set, to show that they are ignored. The field pulse is summed over one frame with and without stretching, and the sums must be exactly one line and one field long.

// File: rtl/htg_pkg.sv
package htg_pkg;
    localparam int TW = 16;
    localparam int CW = 6;
    localparam int AW = 3;

    typedef logic [TW-1:0] cnt_t;
    typedef logic [CW-1:0] code_t;

    localparam code_t CUSTOM_CODE = code_t'(62);

    localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADDR_HSTD = 3'd1;
    localparam logic [AW-1:0] ADDR_LINE = 3'd2;
    localparam logic [AW-1:0] ADDR_HSW  = 3'd3;
    localparam logic [AW-1:0] ADDR_SAV  = 3'd4;
    localparam logic [AW-1:0] ADDR_EAV  = 3'd5;

    typedef struct packed {
        cnt_t line_len;
        cnt_t hs_len;
        cnt_t sav_pos;
        cnt_t eav_pos;
    } htiming_t;

    function automatic htiming_t builtin_timing(input code_t code);
        htiming_t t;
        case (code)
            code_t'(1): t = '{line_len: cnt_t'(48), hs_len: cnt_t'(6),
                              sav_pos: cnt_t'(12), eav_pos: cnt_t'(44)};
            default:    t = '{line_len: cnt_t'(32), hs_len: cnt_t'(4),
                              sav_pos: cnt_t'(8),  eav_pos: cnt_t'(28)};
        endcase
        return t;
    endfunction
endpackage

// File: rtl/htg_regs.sv
module htg_regs
    import htg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  cnt_t          wdata,
    input  logic          we,
    input  code_t         pins,
    output cnt_t          rdata,
    output htiming_t      timing_o,
    output logic          stretch_o
);
    logic     host_sel_q;
    logic     stretch_q;
    code_t    host_std_q;
    htiming_t cust_q;
    code_t    eff_code;
    logic     is_custom;
    cnt_t     rd_mux;

    always_comb begin
        eff_code  = host_sel_q ? host_std_q : pins;
        is_custom = (eff_code == CUSTOM_CODE);
        timing_o  = is_custom ? cust_q : builtin_timing(eff_code);
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rd_mux = {{(TW-2){1'b0}}, stretch_q, host_sel_q};
            ADDR_HSTD: rd_mux = {{(TW-CW){1'b0}}, host_std_q};
            ADDR_LINE: rd_mux = timing_o.line_len;
            ADDR_HSW:  rd_mux = timing_o.hs_len;
            ADDR_SAV:  rd_mux = timing_o.sav_pos;
            ADDR_EAV:  rd_mux = timing_o.eav_pos;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_sel_q <= 1'b0;
            stretch_q  <= 1'b0;
            host_std_q <= '0;
            cust_q     <= builtin_timing('0);
            rdata      <= '0;
        end else begin
            rdata <= rd_mux;
            if (we) begin
                case (addr)
                    ADDR_CTRL: begin
                        host_sel_q <= wdata[0];
                        stretch_q  <= wdata[1];
                    end
                    ADDR_HSTD: host_std_q <= wdata[CW-1:0];
                    ADDR_LINE: if (is_custom) cust_q.line_len <= wdata;
                    ADDR_HSW:  if (is_custom) cust_q.hs_len   <= wdata;
                    ADDR_SAV:  if (is_custom) cust_q.sav_pos  <= wdata;
                    ADDR_EAV:  if (is_custom) cust_q.eav_pos  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign stretch_o = stretch_q;
endmodule

// File: rtl/htg_hcount.sv
module htg_hcount
    import htg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  htiming_t next_timing,
    output cnt_t     hcnt,
    output htiming_t cur,
    output logic     line_end,
    output logic     hsync,
    output logic     active,
    output logic     sav_stb,
    output logic     eav_stb,
    output logic     line_start
);
    always_comb begin
        line_end   = (hcnt + cnt_t'(1) >= cur.line_len);
        hsync      = (hcnt < cur.hs_len);
        active     = (hcnt >= cur.sav_pos) && (hcnt < cur.eav_pos);
        sav_stb    = (hcnt == cur.sav_pos);
        eav_stb    = (hcnt == cur.eav_pos);
        line_start = (hcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            cur  <= builtin_timing('0);
        end else if (line_end) begin
            hcnt <= '0;
            cur  <= next_timing;
        end else begin
            hcnt <= hcnt + cnt_t'(1);
        end
    end
endmodule

// File: rtl/htg_field.sv
module htg_field #(
    parameter int LINES_PER_FIELD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_end,
    input  logic stretch,
    output logic field_id
);
    localparam int LW = (LINES_PER_FIELD > 2) ? $clog2(LINES_PER_FIELD) : 1;
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES_PER_FIELD - 1);

    logic [LW-1:0] vcnt;
    logic          odd_field;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt      <= '0;
            odd_field <= 1'b0;
        end else if (line_end) begin
            if (vcnt == LAST_LINE) begin
                vcnt      <= '0;
                odd_field <= ~odd_field;
            end else begin
                vcnt <= vcnt + LW'(1);
            end
        end
    end

    assign field_id = !odd_field && (stretch || (vcnt == '0));
endmodule

// File: rtl/hline_timing_gen.sv
module hline_timing_gen
    import htg_pkg::*;
#(
    parameter int LINES_PER_FIELD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_we,
    output logic [15:0] reg_rdata,
    input  logic [5:0]  std_pins,
    output logic        hsync,
    output logic        active,
    output logic        sav_stb,
    output logic        eav_stb,
    output logic        line_start,
    output logic        field_id
);
    htiming_t next_t;
    htiming_t cur_t;
    cnt_t     hcnt;
    cnt_t     cur_len;
    logic     line_end;
    logic     stretch;

    htg_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .pins(std_pins), .rdata(reg_rdata), .timing_o(next_t), .stretch_o(stretch)
    );

    htg_hcount u_hcount (
        .clk(clk), .rst(rst), .next_timing(next_t), .hcnt(hcnt), .cur(cur_t),
        .line_end(line_end), .hsync(hsync), .active(active), .sav_stb(sav_stb),
        .eav_stb(eav_stb), .line_start(line_start)
    );

    htg_field #(.LINES_PER_FIELD(LINES_PER_FIELD)) u_field (
        .clk(clk), .rst(rst), .line_end(line_end), .stretch(stretch),
        .field_id(field_id)
    );

    assign cur_len = cur_t.line_len;
endmodule

// File: rtl/hline_timing_gen_chk.sv
module hline_timing_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] hcnt,
    input logic [15:0] cur_len,
    input logic        active,
    input logic        sav_stb,
    input logic        line_start,
    input logic        field_id,
    input logic        stretch
);
    AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        hcnt < cur_len); // R2

    AST_NO_PARTIAL_LINE: assert property (@(posedge clk) disable iff (rst)
        (hcnt + 16'd1 < cur_len) |=> (hcnt == $past(hcnt) + 16'd1)); // R10

    AST_LEN_HELD_MIDLINE: assert property (@(posedge clk) disable iff (rst)
        (hcnt + 16'd1 < cur_len) |=> $stable(cur_len)); // R10

    AST_ACTIVE_OPENS_AT_SAV: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> sav_stb); // R4

    AST_FID_ON_LINE_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(field_id) && $stable(stretch)) |-> line_start); // R9
endmodule

bind hline_timing_gen hline_timing_gen_chk chk_i (
    .clk(clk), .rst(rst), .hcnt(hcnt), .cur_len(cur_len), .active(active),
    .sav_stb(sav_stb), .line_start(line_start), .field_id(field_id),
    .stretch(stretch)
);

// File: tb/hline_timing_gen_tb_top.sv
module hline_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic [5:0]  std_pins;
    logic        hsync, active, sav_stb, eav_stb, line_start, field_id;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    hline_timing_gen #(.LINES_PER_FIELD(4)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .std_pins(std_pins),
        .hsync(hsync), .active(active), .sav_stb(sav_stb), .eav_stb(eav_stb),
        .line_start(line_start), .field_id(field_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr  = 3'(a);
        reg_wdata = 16'(d);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 3'(a);
        reg_we   = 1'b0;
        @(negedge clk);
        d = int'(reg_rdata);
    endtask

    task automatic sync_ls();
        while (!line_start) @(negedge clk);
    endtask

    task automatic measure_line(output int per, output int hs, output int act,
                                output int savp, output int eavp);
        sync_ls();
        per = 0; hs = 0; act = 0; savp = -1; eavp = -1;
        do begin
            if (hsync)   hs++;
            if (active)  act++;
            if (sav_stb) savp = per;
            if (eav_stb) eavp = per;
            per++;
            @(negedge clk);
        end while (!line_start && per < 1000);
    endtask

    task automatic check_line(input string req, input int l, input int h,
                              input int s, input int e);
        int per, hs, act, savp, eavp;
        measure_line(per, hs, act, savp, eavp);
        chk({req, " R2 period"}, per, l);
        chk({req, " R3 hsync width"}, hs, h);
        chk({req, " R4 sav offset"}, savp, s);
        chk({req, " R4 eav offset"}, eavp, e);
        chk({req, " R4 active length"}, act, e - s);
    endtask

    task automatic skip_line();
        int per, hs, act, savp, eavp;
        measure_line(per, hs, act, savp, eavp);
    endtask

    task automatic fid_sum(input int cycles, output int sum);
        sync_ls();
        sum = 0;
        for (int i = 0; i < cycles; i++) begin
            if (field_id) sum++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v, n;
        rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; std_pins = 6'd0;
        repeat (3) @(negedge clk);
        chk("R1 line_start in reset", int'(line_start), 1);
        rst = 1'b0;
        rd(0, v); chk("R1 control reset", v, 0);
        rd(1, v); chk("R1 host std reset", v, 0);
        rd(2, v); chk("R11 R5 line reg code0", v, 32);
        rd(3, v); chk("R11 R5 hsw reg code0", v, 4);

        check_line("R5 code0", 32, 4, 8, 28);

        // R10: switch code mid-line; current line keeps old length
        sync_ls();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) std_pins = 6'd1;
        end while (!line_start && n < 1000);
        chk("R10 line across switch", n, 32);
        check_line("R5 R10 code1", 48, 6, 12, 44);
        rd(4, v); chk("R11 R5 sav reg code1", v, 12);

        // R5 fallback for unknown code
        std_pins = 6'd5;
        skip_line();
        check_line("R5 fallback", 32, 4, 8, 28);
        rd(5, v); chk("R5 eav reg fallback", v, 28);

        // R6 writes ignored when not custom
        wr(2, 100);
        rd(2, v); chk("R6 ignored write readback", v, 32);
        check_line("R6 ignored write", 32, 4, 8, 28);

        // R7 host select
        wr(1, 1);
        wr(0, 1);
        rd(0, v); chk("R7 control readback", v, 1);
        std_pins = 6'd62;
        skip_line();
        check_line("R7 host code1 pins62", 48, 6, 12, 44);
        std_pins = 6'd0;
        check_line("R7 host code1 pins0", 48, 6, 12, 44);

        // R8 host std width
        wr(1, 16'hFFFF);
        rd(1, v); chk("R8 host std upper zero", v, 63);
        skip_line();
        check_line("R5 code63 fallback", 32, 4, 8, 28);

        // R6 custom mode via host
        wr(1, 62);
        wr(2, 20); wr(3, 3); wr(4, 5); wr(5, 17);
        rd(2, v); chk("R6 custom line", v, 20);
        rd(3, v); chk("R6 custom hsw", v, 3);
        rd(4, v); chk("R6 custom sav", v, 5);
        rd(5, v); chk("R6 custom eav", v, 17);
        skip_line();
        check_line("R6 custom", 20, 3, 5, 17);

        // R9 field id, one frame = 2 fields x 4 lines x 20 cycles
        fid_sum(160, v); chk("R9 fid one line", v, 20);
        wr(0, 3);
        fid_sum(160, v); chk("R9 fid stretched", v, 80);

        // R6 custom via pins with host select cleared
        wr(0, 0);
        std_pins = 6'd62;
        skip_line();
        check_line("R6 custom via pins", 20, 3, 5, 17);
        std_pins = 6'd1;
        wr(3, 9);
        rd(3, v); chk("R6 code1 write dropped", v, 6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule